// File: doc/BRIEF.md
# Address Translation Buffer with Two-Level Table Walker

This block translates 32-bit virtual addresses into physical addresses for a single requester. It keeps eight recent translations in a fully associative store. Every stored entry is compared against the virtual page number of the request at the same time. On a match, the stored frame number is joined to the untouched 12-bit page offset, and the request completes in the same cycle without any memory traffic.

When no entry matches, an internal walker fetches the translation from an in-memory two-level page table, starting at the table root given on `root_base`. The walker uses a simple request/acknowledge read port. The first read returns the base of a second-level table, and the second read returns the frame entry. If both entries are present, the translation is stored in the entry chosen by a rotating replacement pointer, and the original request then completes from the store. If either entry is absent, the request completes with a fault indication and nothing is stored. A flush input clears every entry. It is used on a context switch or when a new root is loaded.

Top module: `tlbw_top`

## Requirements
- R1: When `req_valid` is high and the virtual page number (`req_vaddr[31:12]`) matches a valid entry, `req_ready` is high in that same cycle. `resp_paddr` equals {stored frame number, `req_vaddr[11:0]`}, `resp_fault` is low, and no memory read is made.
- R2: On a miss, the first memory read is at address {`root_base[31:12]`, `req_vaddr[31:22]`, 2'b00}.
- R3: Each table entry read from memory has a present flag in bit 0 and a 20-bit payload in bits 31:12. When the first-level entry is present, the second read is at {first-level payload, `req_vaddr[21:12]`, 2'b00}. An entry read with bit 0 low causes a fault in the next cycle.
- R4: When both entries are present, the payload of the second-level entry is stored as the frame number. The request then completes with `resp_paddr` = {that payload, `req_vaddr[11:0]`}. A later request to the same page hits under R1.
- R5: When either entry is absent, `req_ready` and `resp_fault` are high together for exactly one cycle and no entry is written. A repeated request to the same page walks again.
- R6: A cycle with `flush` high invalidates every entry. The next request to any page walks the table under the `root_base` value current at that time.
- R7: Refills go to entries 0,1,...,7 in rotation and then wrap. The pointer returns to entry 0 on reset or flush, and faults do not advance it. The ninth distinct refill after a flush therefore evicts the first one.
- R8: `mem_req` stays high, with `mem_addr` unchanged, until the cycle in which `mem_ack` is high. `mem_rdata` is taken in that cycle.
- R9: During reset and in the cycle after it, no entry is valid and `mem_req` is low. After reset with no request present, `req_ready` and `resp_fault` are low.
- R10: While a walk is in progress (`mem_req` high), `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and reset the replacement pointer |
| root_base | input | 32 | Physical base of the first-level table (bits 31:12 used) |
| req_valid | input | 1 | Translation request present; hold until ready |
| req_vaddr | input | 32 | Virtual address to translate; hold until ready |
| req_ready | output | 1 | Request completes this cycle |
| resp_paddr | output | 32 | Physical address, meaningful when ready and not fault |
| resp_fault | output | 1 | Request completes with a missing mapping |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address (word aligned) |
| mem_ack | input | 1 | Read accepted; data valid this cycle |
| mem_rdata | input | 32 | Table entry read from memory |

## Verification
Directed sequences first show that a repeated page is served with zero reads, while a new page costs exactly two reads. They then separate a first-level absence (one read, then a fault) from a second-level absence (two reads, then a fault, with a junk frame that must not be stored). A sweep over nine present pages after a flush shows which page the rotation evicts. A flush followed by a root change shows that both the old entries and the old table are gone. Random requests drawn from a small page pool, with a memory that answers after varying delays and with occasional flushes, mix hits, refills, evictions and faults. The read count per request tells a hit, a refill and each kind of fault apart.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PFN_W   = 20;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int PTE_W   = 32;
    localparam int ENTRIES = 8;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_LVL1,
        WK_LVL2,
        WK_FAULT
    } walk_state_t;

    function automatic logic pte_present(input logic [PTE_W-1:0] pte);
        return pte[0];
    endfunction

    // The table index plus the 2-bit word offset fills the 12 offset bits.
    function automatic logic [PTE_W-1:0] lvl1_addr(input logic [PTE_W-1:0] root,
                                                   input logic [VPN_W-1:0] vpn);
        return {root[PTE_W-1:OFF_W], vpn[VPN_W-1:IDX_W], 2'b00};
    endfunction

    function automatic logic [PTE_W-1:0] lvl2_addr(input logic [PTE_W-OFF_W-1:0] base,
                                                   input logic [VPN_W-1:0] vpn);
        return {base, vpn[IDX_W-1:0], 2'b00};
    endfunction
endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam
    import tlbw_pkg::*;
#(
    parameter int N = ENTRIES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic [N-1:0]     valid_vec
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    tlb_entry_t       ents [N];
    logic [PTR_W-1:0] victim;
    logic [N-1:0]     match;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || flush) begin
                ents[i] <= '0;
            end else if (wr_en && victim == PTR_W'(i)) begin
                ents[i] <= '{valid: 1'b1, vpn: wr_vpn, pfn: wr_pfn};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            victim <= '0;
        end else if (wr_en) begin
            victim <= (victim == PTR_W'(N - 1)) ? '0 : victim + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g]     = ents[g].valid && (ents[g].vpn == look_vpn);
            assign valid_vec[g] = ents[g].valid;
        end
    endgenerate

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_pfn = hit_pfn | ents[i].pfn;
        end
    end

    assign hit = |match;
endmodule

// File: rtl/tlbw_walker.sv
module tlbw_walker
    import tlbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PTE_W-1:0] root,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             mem_req,
    output logic [PTE_W-1:0] mem_addr,
    output logic             refill_en,
    output logic [PFN_W-1:0] refill_pfn,
    output logic             idle,
    output logic             fault
);
    walk_state_t             state;
    logic [VPN_W-1:0]        vpn_q;
    logic [PTE_W-OFF_W-1:0]  l2_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WK_IDLE;
            vpn_q   <= '0;
            l2_base <= '0;
        end else begin
            unique case (state)
                WK_IDLE: if (start) begin
                    state <= WK_LVL1;
                    vpn_q <= vpn;
                end
                WK_LVL1: if (mem_ack) begin
                    if (pte_present(mem_rdata)) begin
                        l2_base <= mem_rdata[PTE_W-1:OFF_W];
                        state   <= WK_LVL2;
                    end else begin
                        state <= WK_FAULT;
                    end
                end
                WK_LVL2: if (mem_ack) begin
                    state <= pte_present(mem_rdata) ? WK_IDLE : WK_FAULT;
                end
                WK_FAULT: state <= WK_IDLE;
                default:  state <= WK_IDLE;
            endcase
        end
    end

    assign mem_req    = (state == WK_LVL1) || (state == WK_LVL2);
    assign mem_addr   = (state == WK_LVL2) ? lvl2_addr(l2_base, vpn_q) : lvl1_addr(root, vpn_q);
    assign refill_en  = (state == WK_LVL2) && mem_ack && pte_present(mem_rdata);
    assign refill_pfn = mem_rdata[PTE_W-1:PTE_W-PFN_W];
    assign idle       = (state == WK_IDLE);
    assign fault      = (state == WK_FAULT);
endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
    import tlbw_pkg::*;
#(
    parameter int ENTRIES = tlbw_pkg::ENTRIES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PTE_W-1:0] root_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             mem_req,
    output logic [PTE_W-1:0] mem_addr,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata
);
    logic [VPN_W-1:0]   look_vpn;
    logic               hit;
    logic [PFN_W-1:0]   hit_pfn;
    logic [ENTRIES-1:0] valid_vec;
    logic               refill_en;
    logic [PFN_W-1:0]   refill_pfn;
    logic               wk_idle;
    logic               wk_fault;
    logic               start_walk;

    assign look_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign start_walk = req_valid && !hit && !flush;

    tlbw_cam #(.N(ENTRIES)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .look_vpn  (look_vpn),
        .wr_en     (refill_en),
        .wr_vpn    (look_vpn),
        .wr_pfn    (refill_pfn),
        .hit       (hit),
        .hit_pfn   (hit_pfn),
        .valid_vec (valid_vec)
    );

    tlbw_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (start_walk),
        .vpn        (look_vpn),
        .root       (root_base),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .refill_en  (refill_en),
        .refill_pfn (refill_pfn),
        .idle       (wk_idle),
        .fault      (wk_fault)
    );

    // A refill lands in the store one edge before the idle cycle that
    // answers, so the answer always comes from the stored entry.
    assign req_ready  = (wk_idle && req_valid && hit) || wk_fault;
    assign resp_fault = wk_fault;
    assign resp_paddr = {hit_pfn, req_vaddr[OFF_W-1:0]};
endmodule

// File: rtl/tlbw_chk.sv
module tlbw_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         flush,
    input logic         req_ready,
    input logic         resp_fault,
    input logic         mem_req,
    input logic         mem_ack,
    input logic [31:0]  mem_addr,
    input logic [31:0]  mem_rdata,
    input logic [N-1:0] valid_vec
);
    a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r10_no_ready_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    a_r5_fault_one_cycle: assert property (@(posedge clk) disable iff (rst)
        resp_fault |=> !resp_fault);

    a_r5_fault_with_ready: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> req_ready);

    a_r3_absent_faults: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_rdata[0]) |=> resp_fault);

    a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> ((valid_vec == '0) && !mem_req));
endmodule

bind tlbw_top tlbw_chk #(.N(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .req_ready  (req_ready),
    .resp_fault (resp_fault),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .valid_vec  (valid_vec)
);

// File: tb/test_tlbw_top.sv
module test_tlbw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [31:0] root_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int mem_reads = 0;
    int dly = 0;

    logic        m_v   [8];
    logic [19:0] m_vpn [8];
    int          m_ptr = 0;

    always #2 clk = ~clk;

    tlbw_top i_tlbw_top (
        .clk(clk), .rst(rst), .flush(flush), .root_base(root_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic bit l1_ok(input logic [9:0] i1);
        return (i1 % 7) != 6;
    endfunction

    function automatic bit l2_ok(input logic [3:0] rs, input logic [9:0] i1, input logic [9:0] i2);
        return ((int'(i1) + int'(i2) + int'(rs)) % 5) != 4;
    endfunction

    function automatic logic [19:0] pfn_of(input logic [3:0] rs, input logic [9:0] i1, input logic [9:0] i2);
        logic [19:0] a;
        logic [19:0] b;
        a = 20'(i1) * 20'd37;
        b = 20'(i2) * 20'd1021;
        return {rs, 16'h0} ^ a ^ b ^ 20'h5_0000;
    endfunction

    function automatic logic [31:0] table_word(input logic [31:0] a);
        if (a[31:28] == 4'h0) begin
            if (l1_ok(a[11:2])) return {4'h2, a[23:20], a[11:2], 2'b00, 11'h0, 1'b1};
            return 32'h0;
        end
        if (l2_ok(a[27:24], a[23:14], a[11:2]))
            return {pfn_of(a[27:24], a[23:14], a[11:2]), 11'h0, 1'b1};
        return {pfn_of(a[27:24], a[23:14], a[11:2]), 12'h0};
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (dly == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = table_word(mem_addr);
                    mem_reads++;
                    dly = $urandom % 3;
                end else begin
                    dly--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic xlate(input logic [31:0] va, input string force_tag);
        logic [3:0]  rs;
        logic [9:0]  i1;
        logic [9:0]  i2;
        bit          mhit;
        bit          efault;
        int          ereads;
        int          r0;
        int          waits;
        logic [31:0] got_pa;
        logic        got_ready;
        logic        got_fault;
        string       tag;
        rs = root_base[23:20];
        i1 = va[31:22];
        i2 = va[21:12];
        mhit = 1'b0;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == va[31:12]) mhit = 1'b1;
        efault = !mhit && !(l1_ok(i1) && l2_ok(rs, i1, i2));
        ereads = mhit ? 0 : (l1_ok(i1) ? 2 : 1);
        tag = (force_tag != "") ? force_tag : (mhit ? "R1" : (efault ? "R5" : "R4"));
        r0 = mem_reads;
        waits = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        got_ready = 1'b0;
        forever begin
            #1;
            if (req_ready) begin
                got_ready = 1'b1;
                break;
            end
            @(negedge clk);
            waits++;
            if (waits > 200) break;
        end
        got_pa    = resp_paddr;
        got_fault = resp_fault;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(got_ready == 1'b1, tag, "ready seen", 32'(got_ready), 32'd1);
        chk(got_fault == efault, tag, "fault", 32'(got_fault), 32'(efault));
        chk(mem_reads - r0 == ereads, tag, "table reads", 32'(mem_reads - r0), 32'(ereads));
        if (mhit) chk(waits == 0, "R1", "same-cycle hit", 32'(waits), 32'd0);
        if (!efault)
            chk(got_pa == {pfn_of(rs, i1, i2), va[11:0]}, tag, "paddr", got_pa,
                {pfn_of(rs, i1, i2), va[11:0]});
        if (!mhit && !efault) begin
            m_v[m_ptr]   = 1'b1;
            m_vpn[m_ptr] = va[31:12];
            m_ptr = (m_ptr + 1) % 8;
        end
    endtask

    function automatic logic [31:0] mk_va(input int a, input int b, input int off);
        return {10'(a), 10'(b), 12'(off)};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int sel [9];
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready == 1'b0, "R9", "ready in reset", 32'(req_ready), 32'd0);
        chk(mem_req == 1'b0, "R9", "mem_req in reset", 32'(mem_req), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b0 && resp_fault == 1'b0, "R9", "idle outputs",
            {30'd0, req_ready, resp_fault}, 32'd0);
        chk(mem_req == 1'b0, "R9", "idle mem_req", 32'(mem_req), 32'd0);

        // R2 R3 R4: walk and refill, then R1 hit
        xlate(mk_va(1, 0, 'habc), "R2");
        xlate(mk_va(1, 0, 'h123), "R1");
        // R5: first-level absent, twice (no refill)
        xlate(mk_va(6, 0, 'h010), "R5");
        xlate(mk_va(6, 0, 'h020), "R5");
        // R3 R5: second-level absent
        xlate(mk_va(1, 2, 'h030), "R3");
        xlate(mk_va(1, 2, 'h040), "R5");

        // R7: nine present pages after a flush, then rotation eviction
        do_flush();
        n = 0;
        for (int b = 0; b < 40 && n < 9; b++) begin
            if (l2_ok(root_base[23:20], 10'd2, 10'(b))) begin
                sel[n] = b;
                n++;
            end
        end
        for (int k = 0; k < 9; k++) xlate(mk_va(2, sel[k], k), "R7");
        xlate(mk_va(2, sel[0], 'h5), "R7");
        xlate(mk_va(2, sel[2], 'h6), "R7");
        xlate(mk_va(2, sel[8], 'h7), "R7");

        // R6: flush drops entries; new root changes results
        xlate(mk_va(2, sel[8], 'h8), "R6");
        do_flush();
        xlate(mk_va(2, sel[8], 'h9), "R6");
        do_flush();
        root_base = 32'h0030_0000;
        xlate(mk_va(2, sel[8], 'ha), "R6");
        xlate(mk_va(1, 0, 'hb), "R6");

        // random mix
        for (int t = 0; t < 300; t++) begin
            if ($urandom % 40 == 0) do_flush();
            if ($urandom % 60 == 0) begin
                do_flush();
                root_base = ($urandom % 2) ? 32'h0010_0000 : 32'h0050_0000;
            end
            xlate(mk_va($urandom % 16, $urandom % 4, $urandom % 4096), "");
        end
        finish_run();
    end
endmodule